// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of exception entry for a processor core. A general request brings a cause code, the address of the faulting instruction and, optionally, a faulting data address. A debug request brings its own cause and instruction address. On the clock edge that accepts a request, the block rewrites the status word and the save registers together. In the cycle that follows it raises a one-cycle take strobe with a two-bit vector select. The fetch unit turns that select into a handler address and flushes the pipeline. Neither of those tasks is part of this block.

The vector depends on the status word. If a general exception arrives while the status is already in exception mode, the block takes the double-exception vector. The instruction address then goes to a dedicated double-exception save register when the `has_dpc` configuration input says one exists. Otherwise it goes to the level-1 save register. Outside exception mode the instruction address always goes to the level-1 save register, and the user-mode bit chooses between the user and kernel vectors. A debug request is accepted only below a fixed debug interrupt level. It saves the whole old status word and raises the interrupt level to the debug level. A separate load port lets the return path write the status word.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, every output register reads zero, `take` is 0 and `vec_sel` is 0.
- R2: A general request accepted with status bit 4 (exception mode) clear writes `exc_pc` to `epc_l1`. It takes `vec_sel` = 1 (user) when status bit 5 (user mode) is set and `vec_sel` = 0 (kernel) when bit 5 is clear.
- R3: A general request accepted with status bit 4 set takes `vec_sel` = 2 (double). It writes `exc_pc` to `epc_dbl` when `has_dpc` is 1 and to `epc_l1` when `has_dpc` is 0. The other of the two registers keeps its value.
- R4: Every accepted general request writes `exc_cause` to `cause` and sets status bit 4. All other status bits keep their values.
- R5: `fault_addr` takes `exc_vaddr` only on an accepted general request with `exc_has_addr` high. At any other time it holds its value.
- R6: A debug request is accepted only when the status interrupt level (bits 3:0) is strictly less than `DBG_LEVEL`. Otherwise the request is ignored: no strobe, and no register changes unless the status load port writes the status word.
- R7: An accepted debug request writes `dbg_cause` to `dbg_cause_q` and `dbg_pc` to `epc_dbg`. It also writes the full status word held before the edge to `eps_dbg`, and takes `vec_sel` = 3 (debug).
- R8: After debug entry, status bits 3:0 equal `DBG_LEVEL`, bit 4 is set, and all other bits are unchanged.
- R9: When both requests arrive together and the debug request is accepted, the debug request wins. The general request is dropped: `cause`, `epc_l1`, `epc_dbl` and `fault_addr` keep their values, and one strobe is raised.
- R10: `take` is high for exactly the cycle after each edge that accepted a request, with `vec_sel` valid in that cycle. The save registers change only on such edges.
- R11: `st_load` writes `st_load_val` to the status word on an edge where no request is accepted. On an edge that accepts a request, the request's status update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| has_dpc | input | 1 | Configuration: a dedicated double-exception save register exists |
| exc_req | input | 1 | General exception request |
| exc_cause | input | CAUSE_W | Cause code of the general request |
| exc_pc | input | PC_W | Faulting instruction address |
| exc_has_addr | input | 1 | The request carries a faulting data address |
| exc_vaddr | input | PC_W | Faulting data address |
| dbg_req | input | 1 | Debug exception request |
| dbg_cause | input | DCAUSE_W | Debug cause code |
| dbg_pc | input | PC_W | Instruction address saved on debug entry |
| st_load | input | 1 | Write the status word from the return path |
| st_load_val | input | 16 | Status value to load |
| take | output | 1 | One-cycle exception-taken strobe |
| vec_sel | output | 2 | Vector: 0 kernel, 1 user, 2 double, 3 debug |
| status | output | 16 | Status word: 3:0 interrupt level, 4 exception mode, 5 user mode |
| epc_l1 | output | PC_W | Level-1 saved instruction address |
| epc_dbl | output | PC_W | Double-exception saved instruction address |
| cause | output | CAUSE_W | Cause register |
| fault_addr | output | PC_W | Faulting data address register |
| dbg_cause_q | output | DCAUSE_W | Debug cause register |
| epc_dbg | output | PC_W | Saved instruction address for the debug level |
| eps_dbg | output | 16 | Saved status word for the debug level |

## Verification
A general request and a debug request can arrive on the same edge. The bench provokes this with directed cases at an interrupt level below and at `DBG_LEVEL`, and with random traffic in which the two request lines are drawn independently. Below the debug level, it expects only the debug registers and the debug status to change, with one strobe. At or above the debug level, the general path must proceed as if no debug request had arrived. A status load in the same cycle as an accepted request is provoked the same way, and the bench expects the request's status update to win.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int ST_W     = 16;
  localparam int IL_W     = 4;
  localparam int EXCM_BIT = 4;
  localparam int UM_BIT   = 5;

  typedef enum logic [1:0] {
    VEC_KERNEL = 2'd0,
    VEC_USER   = 2'd1,
    VEC_DOUBLE = 2'd2,
    VEC_DEBUG  = 2'd3
  } vec_e;

  // Vector chosen for a general exception from the two mode bits.
  function automatic vec_e f_general_vec(input logic excm, input logic um);
    if (excm)    return VEC_DOUBLE;
    else if (um) return VEC_USER;
    else         return VEC_KERNEL;
  endfunction

  // Status after a general exception: only exception mode is forced on.
  function automatic logic [ST_W-1:0] f_status_general(input logic [ST_W-1:0] st);
    logic [ST_W-1:0] r;
    r = st;
    r[EXCM_BIT] = 1'b1;
    return r;
  endfunction

  // Status after debug entry: interrupt level raised, exception mode set.
  function automatic logic [ST_W-1:0] f_status_debug(input logic [ST_W-1:0] st,
                                                     input logic [IL_W-1:0] lvl);
    logic [ST_W-1:0] r;
    r = st;
    r[IL_W-1:0] = lvl;
    r[EXCM_BIT] = 1'b1;
    return r;
  endfunction

  // A debug request passes only below the debug level.
  function automatic logic f_debug_allowed(input logic [IL_W-1:0] cur,
                                           input logic [IL_W-1:0] lvl);
    return cur < lvl;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int DBG_LEVEL = 3
) (
  input  logic            exc_req,
  input  logic            dbg_req,
  input  logic [IL_W-1:0] cur_level,
  input  logic            cur_excm,
  input  logic            cur_um,
  output logic            dbg_fire,
  output logic            gen_fire,
  output logic            gen_double,
  output vec_e            vec_nxt
);

  localparam logic [IL_W-1:0] LVL = IL_W'(DBG_LEVEL);

  logic dbg_ok;

  always_comb begin
    dbg_ok     = f_debug_allowed(cur_level, LVL);
    dbg_fire   = dbg_req && dbg_ok;
    gen_fire   = exc_req && !dbg_fire;
    gen_double = cur_excm;
    if (dbg_fire) vec_nxt = VEC_DEBUG;
    else          vec_nxt = f_general_vec(cur_excm, cur_um);
  end

endmodule

// File: rtl/exc_status_reg.sv
module exc_status_reg
  import exc_entry_pkg::*;
#(
  parameter int DBG_LEVEL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dbg_fire,
  input  logic            gen_fire,
  input  logic            st_load,
  input  logic [ST_W-1:0] st_load_val,
  output logic [ST_W-1:0] status_q
);

  localparam logic [IL_W-1:0] LVL = IL_W'(DBG_LEVEL);

  logic [ST_W-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (dbg_fire)      status_d = f_status_debug(status_q, LVL);
    else if (gen_fire) status_d = f_status_general(status_q);
    else if (st_load)  status_d = st_load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
  import exc_entry_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int CAUSE_W  = 6,
  parameter int DCAUSE_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dbg_fire,
  input  logic                gen_fire,
  input  logic                gen_double,
  input  logic                has_dpc,
  input  logic [CAUSE_W-1:0]  exc_cause,
  input  logic [PC_W-1:0]     exc_pc,
  input  logic                exc_has_addr,
  input  logic [PC_W-1:0]     exc_vaddr,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  input  logic [PC_W-1:0]     dbg_pc,
  input  logic [ST_W-1:0]     status_q,
  output logic [PC_W-1:0]     epc_l1_q,
  output logic [PC_W-1:0]     epc_dbl_q,
  output logic [CAUSE_W-1:0]  cause_q,
  output logic [PC_W-1:0]     vaddr_q,
  output logic [DCAUSE_W-1:0] dcause_q,
  output logic [PC_W-1:0]     epc_dbg_q,
  output logic [ST_W-1:0]     eps_dbg_q
);

  logic to_dbl_reg;
  logic wr_l1;
  logic wr_dbl;
  logic wr_vaddr;

  always_comb begin
    to_dbl_reg = gen_double && has_dpc;
    wr_l1      = gen_fire && !to_dbl_reg;
    wr_dbl     = gen_fire && to_dbl_reg;
    wr_vaddr   = gen_fire && exc_has_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_l1_q  <= '0;
      epc_dbl_q <= '0;
      cause_q   <= '0;
      vaddr_q   <= '0;
      dcause_q  <= '0;
      epc_dbg_q <= '0;
      eps_dbg_q <= '0;
    end else begin
      if (wr_l1)    epc_l1_q  <= exc_pc;
      if (wr_dbl)   epc_dbl_q <= exc_pc;
      if (gen_fire) cause_q   <= exc_cause;
      if (wr_vaddr) vaddr_q   <= exc_vaddr;
      if (dbg_fire) begin
        dcause_q  <= dbg_cause;
        epc_dbg_q <= dbg_pc;
        eps_dbg_q <= status_q;
      end
    end
  end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DCAUSE_W  = 6,
  parameter int DBG_LEVEL = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                has_dpc,
  input  logic                exc_req,
  input  logic [CAUSE_W-1:0]  exc_cause,
  input  logic [PC_W-1:0]     exc_pc,
  input  logic                exc_has_addr,
  input  logic [PC_W-1:0]     exc_vaddr,
  input  logic                dbg_req,
  input  logic [DCAUSE_W-1:0] dbg_cause,
  input  logic [PC_W-1:0]     dbg_pc,
  input  logic                st_load,
  input  logic [15:0]         st_load_val,
  output logic                take,
  output logic [1:0]          vec_sel,
  output logic [15:0]         status,
  output logic [PC_W-1:0]     epc_l1,
  output logic [PC_W-1:0]     epc_dbl,
  output logic [CAUSE_W-1:0]  cause,
  output logic [PC_W-1:0]     fault_addr,
  output logic [DCAUSE_W-1:0] dbg_cause_q,
  output logic [PC_W-1:0]     epc_dbg,
  output logic [15:0]         eps_dbg
);

  // R8: the debug level must fit the level field and leave room for level 1.
  initial begin
    if (DBG_LEVEL < 2 || DBG_LEVEL >= (1 << IL_W))
      $error("DBG_LEVEL out of range");
  end

  // Internal events, named for the checker.
  logic            dbg_fire;
  logic            gen_fire;
  logic            gen_double;
  vec_e            vec_nxt;
  logic [ST_W-1:0] status_q;
  logic            take_q;
  vec_e            vec_q;

  exc_arbiter #(.DBG_LEVEL(DBG_LEVEL)) u_arb (
    .exc_req    (exc_req),
    .dbg_req    (dbg_req),
    .cur_level  (status_q[IL_W-1:0]),
    .cur_excm   (status_q[EXCM_BIT]),
    .cur_um     (status_q[UM_BIT]),
    .dbg_fire   (dbg_fire),
    .gen_fire   (gen_fire),
    .gen_double (gen_double),
    .vec_nxt    (vec_nxt)
  );

  exc_status_reg #(.DBG_LEVEL(DBG_LEVEL)) u_st (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_fire    (dbg_fire),
    .gen_fire    (gen_fire),
    .st_load     (st_load),
    .st_load_val (st_load_val),
    .status_q    (status_q)
  );

  exc_save_bank #(.PC_W(PC_W), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_fire     (dbg_fire),
    .gen_fire     (gen_fire),
    .gen_double   (gen_double),
    .has_dpc      (has_dpc),
    .exc_cause    (exc_cause),
    .exc_pc       (exc_pc),
    .exc_has_addr (exc_has_addr),
    .exc_vaddr    (exc_vaddr),
    .dbg_cause    (dbg_cause),
    .dbg_pc       (dbg_pc),
    .status_q     (status_q),
    .epc_l1_q     (epc_l1),
    .epc_dbl_q    (epc_dbl),
    .cause_q      (cause),
    .vaddr_q      (fault_addr),
    .dcause_q     (dbg_cause_q),
    .epc_dbg_q    (epc_dbg),
    .eps_dbg_q    (eps_dbg)
  );

  // Strobe and vector register the same edge as the save registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= VEC_KERNEL;
    end else begin
      take_q <= dbg_fire || gen_fire;
      if (dbg_fire || gen_fire) vec_q <= vec_nxt;
    end
  end

  assign take    = take_q;
  assign vec_sel = vec_q;
  assign status  = status_q;

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int PC_W      = 32,
  parameter int CAUSE_W   = 6,
  parameter int DBG_LEVEL = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dbg_fire,
  input logic               gen_fire,
  input logic               take,
  input logic [1:0]         vec_sel,
  input logic [15:0]        status,
  input logic [PC_W-1:0]    epc_l1,
  input logic [PC_W-1:0]    epc_dbl,
  input logic [CAUSE_W-1:0] cause,
  input logic [15:0]        eps_dbg
);

  p_single_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dbg_fire, gen_fire}));

  p_dbg_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_sel == 2'd3) |-> ($past(status[3:0]) < 4'(DBG_LEVEL)));

  p_excm_on_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> status[4]);

  p_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_sel == 2'd2) |-> $past(status[4]));

  p_dbg_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_sel == 2'd3) |-> (status[3:0] == 4'(DBG_LEVEL) && status[4]));

  p_eps_saved_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_sel == 2'd3) |-> (eps_dbg == $past(status)));

  p_quiet_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> ($stable(cause) && $stable(epc_l1) && $stable(epc_dbl)));

endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .PC_W(PC_W), .CAUSE_W(CAUSE_W), .DBG_LEVEL(DBG_LEVEL)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dbg_fire (dbg_fire),
  .gen_fire (gen_fire),
  .take     (take),
  .vec_sel  (vec_sel),
  .status   (status),
  .epc_l1   (epc_l1),
  .epc_dbl  (epc_dbl),
  .cause    (cause),
  .eps_dbg  (eps_dbg)
);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

  localparam int PC_W = 32;
  localparam int CW   = 6;
  localparam int DCW  = 6;
  localparam int DLVL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic has_dpc = 1'b0, exc_req = 1'b0, exc_has_addr = 1'b0, dbg_req = 1'b0, st_load = 1'b0;
  logic [CW-1:0]   exc_cause = '0;
  logic [DCW-1:0]  dbg_cause = '0;
  logic [PC_W-1:0] exc_pc = '0, exc_vaddr = '0, dbg_pc = '0;
  logic [15:0]     st_load_val = '0;

  logic            take;
  logic [1:0]      vec_sel;
  logic [15:0]     status, eps_dbg;
  logic [PC_W-1:0] epc_l1, epc_dbl, fault_addr, epc_dbg;
  logic [CW-1:0]   cause;
  logic [DCW-1:0]  dbg_cause_q;

  exc_entry_ctrl #(.PC_W(PC_W), .CAUSE_W(CW), .DCAUSE_W(DCW), .DBG_LEVEL(DLVL)) i_exc_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .has_dpc(has_dpc), .exc_req(exc_req), .exc_cause(exc_cause),
    .exc_pc(exc_pc), .exc_has_addr(exc_has_addr), .exc_vaddr(exc_vaddr), .dbg_req(dbg_req),
    .dbg_cause(dbg_cause), .dbg_pc(dbg_pc), .st_load(st_load), .st_load_val(st_load_val),
    .take(take), .vec_sel(vec_sel), .status(status), .epc_l1(epc_l1), .epc_dbl(epc_dbl),
    .cause(cause), .fault_addr(fault_addr), .dbg_cause_q(dbg_cause_q), .epc_dbg(epc_dbg),
    .eps_dbg(eps_dbg)
  );

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // Expected state
  logic            m_take;
  logic [1:0]      m_vec;
  logic [15:0]     m_st, m_eps;
  logic [PC_W-1:0] m_l1, m_dbl, m_va, m_dpc;
  logic [CW-1:0]   m_cause;
  logic [DCW-1:0]  m_dc;

  task automatic model_reset();
    m_take = 0; m_vec = 0; m_st = 0; m_eps = 0; m_l1 = 0; m_dbl = 0;
    m_va = 0; m_dpc = 0; m_cause = 0; m_dc = 0;
  endtask

  // Next expected state from current inputs, written from the requirements.
  task automatic model_step();
    bit dbg_ok;
    dbg_ok = dbg_req && (int'(m_st[3:0]) < DLVL);
    m_take = dbg_ok || exc_req;
    if (dbg_ok) begin
      m_vec = 2'd3;
      m_dc  = dbg_cause;
      m_dpc = dbg_pc;
      m_eps = m_st;
      m_st  = {m_st[15:5], 1'b1, 4'(DLVL)};
    end else if (exc_req) begin
      if (m_st[4]) begin
        m_vec = 2'd2;
        if (has_dpc) m_dbl = exc_pc; else m_l1 = exc_pc;
      end else begin
        m_vec = m_st[5] ? 2'd1 : 2'd0;
        m_l1  = exc_pc;
      end
      m_cause = exc_cause;
      if (exc_has_addr) m_va = exc_vaddr;
      m_st = m_st | 16'h0010;
    end else if (st_load) begin
      m_st = st_load_val;
    end
  endtask

  task automatic chk(input string ctx, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, ctx, act, exp);
    end
  endtask

  task automatic compare_all(input string ctx);
    chk(ctx, "R10 take",        32'(take),        32'(m_take));
    chk(ctx, "R2 vec_sel",      32'(vec_sel),     32'(m_vec));
    chk(ctx, "R4 status",       32'(status),      32'(m_st));
    chk(ctx, "R2 epc_l1",       32'(epc_l1),      32'(m_l1));
    chk(ctx, "R3 epc_dbl",      32'(epc_dbl),     32'(m_dbl));
    chk(ctx, "R4 cause",        32'(cause),       32'(m_cause));
    chk(ctx, "R5 fault_addr",   32'(fault_addr),  32'(m_va));
    chk(ctx, "R7 dbg_cause_q",  32'(dbg_cause_q), 32'(m_dc));
    chk(ctx, "R7 epc_dbg",      32'(epc_dbg),     32'(m_dpc));
    chk(ctx, "R7 eps_dbg",      32'(eps_dbg),     32'(m_eps));
  endtask

  // Called at a falling edge: drive, advance one clock, compare at next falling edge.
  task automatic step(input string ctx,
                      input bit er, input logic [CW-1:0] ec, input logic [PC_W-1:0] pc,
                      input bit ha, input logic [PC_W-1:0] va,
                      input bit dr, input logic [DCW-1:0] dc, input logic [PC_W-1:0] dp,
                      input bit ld, input logic [15:0] lv, input bit hd);
    exc_req = er; exc_cause = ec; exc_pc = pc; exc_has_addr = ha; exc_vaddr = va;
    dbg_req = dr; dbg_cause = dc; dbg_pc = dp; st_load = ld; st_load_val = lv; has_dpc = hd;
    model_step();
    @(negedge clk);
    compare_all(ctx);
  endtask

  task automatic idle(input string ctx);
    step(ctx, 0, '0, '0, 0, '0, 0, '0, '0, 0, '0, 0);
  endtask

  initial begin
    void'($urandom(32'h1e57_c0de));
    model_reset();
    @(negedge clk);
    @(negedge clk);
    compare_all("R1 during reset");
    rst_n = 1'b1;
    idle("R1 after reset");

    // R2 kernel entry (user bit clear), with a data address.
    step("R2 kernel entry", 1, 6'd5, 32'h1000_0040, 1, 32'hdead_0000, 0, '0, '0, 0, '0, 0);
    // R11 load while idle: clear exception mode, set user mode.
    step("R11 load user", 0, '0, '0, 0, '0, 0, '0, '0, 1, 16'h0020, 0);
    // R2 user entry, no address: R5 fault address must hold.
    step("R2 R5 user entry", 1, 6'd9, 32'h2000_0080, 0, 32'h1111_1111, 0, '0, '0, 0, '0, 0);
    // R3 double with dedicated register present.
    step("R3 double dpc", 1, 6'd7, 32'h3000_00c0, 0, '0, 0, '0, '0, 0, '0, 1);
    // R3 double without dedicated register.
    step("R3 double no dpc", 1, 6'd8, 32'h4000_0100, 0, '0, 0, '0, '0, 0, '0, 0);
    // R6 debug gated: level equal to DBG_LEVEL.
    step("R6 load level3", 0, '0, '0, 0, '0, 0, '0, '0, 1, 16'h0003, 0);
    step("R6 debug at level", 0, '0, '0, 0, '0, 1, 6'd3, 32'h5000_0000, 0, '0, 0);
    // R9 at level 3 a general request with a debug request proceeds as general.
    step("R9 gated debug plus general", 1, 6'd12, 32'h5100_0000, 1, 32'h0bad_0001, 1, 6'd4, 32'h5200_0000, 0, '0, 0);
    // R7 R8 debug taken at level 2, user bit and upper bits preserved.
    step("R7 load level2", 0, '0, '0, 0, '0, 0, '0, '0, 1, 16'hA022, 0);
    step("R7 R8 debug taken", 0, '0, '0, 0, '0, 1, 6'd33, 32'h6000_0004, 0, '0, 0);
    // R9 simultaneous, debug wins, general dropped.
    step("R9 load level1", 0, '0, '0, 0, '0, 0, '0, '0, 1, 16'h0001, 0);
    step("R9 both requests", 1, 6'd63, 32'h7000_0000, 1, 32'hffff_0000, 1, 6'd17, 32'h7100_0000, 0, '0, 1);
    // R11 load in the same cycle as a taken request: request wins.
    step("R11 load level0", 0, '0, '0, 0, '0, 0, '0, '0, 1, 16'h0000, 0);
    step("R11 load vs take", 1, 6'd2, 32'h8000_0000, 0, '0, 0, '0, '0, 1, 16'h0fff, 0);
    idle("R10 strobe drop");

    // Constrained random traffic.
    for (int i = 0; i < 3000; i++) begin
      bit er, dr, ld, ha, hd;
      logic [15:0] lv;
      er = ($urandom % 2) == 0;
      dr = ($urandom % 4) == 0;
      ld = ($urandom % 3) == 0;
      ha = ($urandom % 2) == 0;
      hd = ($urandom % 2) == 0;
      lv = 16'($urandom);
      lv[3:0] = 4'($urandom % 5);
      lv[4]   = ($urandom % 4) == 0;
      step("R2 R3 R9 random", er, 6'($urandom), $urandom, ha, $urandom,
           dr, 6'($urandom), $urandom, ld, lv, hd);
    end

    // R1 reset reasserted mid-run.
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    compare_all("R1 reset again");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule